// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Bank

This block holds the programmable state of a two-channel serial communications controller. Each channel has sixteen 8-bit write registers and sixteen 8-bit read registers. Software reaches them through one byte-wide control port per channel, using an indirect pointer. A control write made while the pointer is zero loads the pointer. The next control access then reaches the selected register, and the pointer drops back to zero. A separate data port per channel takes transmit bytes and returns the receive-buffer register.

A command field in write register 9 starts one of three resets: a soft reset of either channel, or a hard reset of both channels. Each reset keeps some bits of each affected register and forces others to fixed values. A power-on reset clears everything. A few register writes have side effects. Writing the receive-control register with the hunt bit set raises the sync/hunt status bit. A data-port write marks the transmitter empty and all-sent, and flags a transmit interrupt. All write registers are driven out as a flat configuration bus for the serial engine.

Top module: `sercom_regbank`

## Requirements
- R1: After power-on reset (`rst_n` low), every write and read register of both channels is 0x00, both pointers are 0 and `tx_int` is 0.
- R2: A control-port write made while the channel's pointer is 0 stores the byte into write register 0. It also loads the pointer with `wdata[2:0]`, plus 8 when `wdata[5:3]` equals 3'b001.
- R3: A control-port write made while the pointer is non-zero stores the byte into the write register the pointer selects, and the pointer returns to 0. A control-port read returns the read register the pointer selects and sets the pointer to 0. A data-port read returns read register 8 and leaves the pointer unchanged.
- R4: `bus_ch` = 0 addresses channel B and `bus_ch` = 1 addresses channel A. In a write to register 9, bits 7:6 form a command: 01 soft-resets channel B, 10 soft-resets channel A, and 11 hard-resets both. A command write is not stored. A write with 00 in bits 7:6 is stored.
- R5: A soft reset changes the write registers as follows. WR0 is cleared. WR1 keeps only its 0x24 bits. WR3 clears bit 0. In WR4, bits 3:2 become 01 and the other bits are kept. WR5 keeps only its 0x61 bits. WR9 clears bit 0x20. WR10 keeps only its 0x60 bits. WR14 keeps its 0xC3 bits and sets 0x20. WR15 becomes 0xF8. All other write registers are kept.
- R6: A soft reset changes the read state as follows. RR0 keeps only its 0xB8 bits and sets 0x44. RR1 keeps only bit 0x01 and sets 0x06. RR3 is cleared. RR10 keeps only bit 0x40. The channel's `tx_int` and pointer are cleared.
- R7: A hard reset applies the soft reset to both channels. It then sets WR9 to (WR9 & 0x03) | 0xC0, WR10 to 0x00, WR11 to 0x08, and WR14 to (WR14 & 0xC0) | 0x30.
- R8: A write of WR3 with bit 4 set raises bit 4 (sync/hunt) of RR0. The other RR0 bits are unchanged.
- R9: A data-port write stores the byte in WR8, sets bit 2 (transmit buffer empty) of RR0 and bit 0 (all sent) of RR1, and sets the channel's `tx_int`.
- R10: A soft reset of one channel leaves the other channel's registers, pointer and `tx_int` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_ch | input | 1 | Channel select: 0 = channel B, 1 = channel A |
| bus_is_data | input | 1 | 1 = data port, 0 = control port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cfg_regs | output | 256 | All write registers, channel c register n at bits (c*16+n)*8 +: 8 |
| tx_int | output | 2 | Transmit interrupt pending per channel index |

## Verification
The assertions assume that at most one strobe is active per cycle and that a write and a read never coincide. The bench issues every access as a single-strobe cycle driven between clock edges. The properties also assume that a command write reaches only register 9, since they decode the command from the writer's pointer. The stimulus therefore always loads the pointer with the select byte before writing a value, and it masks bits 7:6 of filler data headed for register 9. Several fill patterns and all three reset commands are swept. Each channel is used both as the writer and as the target, so cross-channel resets are covered as well as self-resets.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

   localparam int REG_W = 8;
   localparam int REG_N = 16;

   typedef logic [REG_N-1:0][REG_W-1:0] bank_t;

   // register indices whose behaviour the bank depends on
   localparam int W_PTR   = 0;
   localparam int W_IEN   = 1;
   localparam int W_RXC   = 3;
   localparam int W_FRM   = 4;
   localparam int W_TXC   = 5;
   localparam int W_TXD   = 8;
   localparam int W_MCTL  = 9;
   localparam int W_ENC   = 10;
   localparam int W_CLK   = 11;
   localparam int W_AUX   = 14;
   localparam int W_LINE  = 15;

   localparam int R_STAT  = 0;
   localparam int R_SPEC  = 1;
   localparam int R_PEND  = 3;
   localparam int R_AUX   = 10;

   localparam logic [7:0] HUNT_BIT   = 8'h10;
   localparam logic [7:0] TXE_BIT    = 8'h04;
   localparam logic [7:0] SENT_BIT   = 8'h01;

   function automatic bank_t soft_wr(input bank_t b);
      bank_t r;
      r = b;
      r[W_PTR]  = 8'h00;
      r[W_IEN]  = b[W_IEN] & 8'h24;
      r[W_RXC]  = b[W_RXC] & 8'hFE;
      r[W_FRM]  = (b[W_FRM] & 8'hF3) | 8'h04;
      r[W_TXC]  = b[W_TXC] & 8'h61;
      r[W_MCTL] = b[W_MCTL] & 8'hDF;
      r[W_ENC]  = b[W_ENC] & 8'h60;
      r[W_AUX]  = (b[W_AUX] & 8'hC3) | 8'h20;
      r[W_LINE] = 8'hF8;
      return r;
   endfunction

   function automatic bank_t hard_wr(input bank_t b);
      bank_t r;
      r = soft_wr(b);
      r[W_MCTL] = (r[W_MCTL] & 8'h03) | 8'hC0;
      r[W_ENC]  = 8'h00;
      r[W_CLK]  = 8'h08;
      r[W_AUX]  = (r[W_AUX] & 8'hC0) | 8'h30;
      return r;
   endfunction

   function automatic bank_t soft_rr(input bank_t b);
      bank_t r;
      r = b;
      r[R_STAT] = (b[R_STAT] & 8'hB8) | 8'h44;
      r[R_SPEC] = (b[R_SPEC] & 8'h01) | 8'h06;
      r[R_PEND] = 8'h00;
      r[R_AUX]  = b[R_AUX] & 8'h40;
      return r;
   endfunction

endpackage

// File: rtl/sercom_ptr.sv
module sercom_ptr #(
   parameter int REG_N = 16,
   parameter int REG_W = 8,
   localparam int PTR_W = $clog2(REG_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ctl_wr,
   input  logic             ctl_rd,
   input  logic [REG_W-1:0] wdata,
   output logic [PTR_W-1:0] ptr
);

   localparam int LO_W = PTR_W - 1;

   logic [PTR_W-1:0] load_val;
   logic             hi_sel;

   // upper-half select: bits 5:3 of the command byte equal to 001
   assign hi_sel   = (wdata[5:3] == 3'b001);
   assign load_val = {hi_sel, wdata[LO_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (ctl_wr) begin
         ptr <= (ptr == '0) ? load_val : '0;
      end else if (ctl_rd) begin
         ptr <= '0;
      end
   end

endmodule

// File: rtl/sercom_chan.sv
module sercom_chan
   import sercom_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int REG_N = 16,
   localparam int PTR_W = $clog2(REG_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             is_data,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             soft_rst,
   input  logic             hard_rst,
   output bank_t            wr_bank,
   output bank_t            rr_bank,
   output logic [PTR_W-1:0] ptr,
   output logic             tx_pend,
   output logic [1:0]       cmd_req
);

   logic ctl_wr, ctl_rd, dat_wr, cmd_hit;

   assign ctl_wr  = acc_en && wr_en && !is_data;
   assign ctl_rd  = acc_en && rd_en && !is_data;
   assign dat_wr  = acc_en && wr_en && is_data;
   assign cmd_hit = ctl_wr && (ptr == PTR_W'(W_MCTL)) && (wdata[7:6] != 2'b00);
   assign cmd_req = cmd_hit ? wdata[7:6] : 2'b00;

   sercom_ptr #(.REG_N(REG_N), .REG_W(REG_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst || hard_rst),
      .ctl_wr (ctl_wr),
      .ctl_rd (ctl_rd),
      .wdata  (wdata),
      .ptr    (ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bank <= '0;
         rr_bank <= '0;
         tx_pend <= 1'b0;
      end else if (hard_rst) begin
         wr_bank <= hard_wr(wr_bank);
         rr_bank <= soft_rr(rr_bank);
         tx_pend <= 1'b0;
      end else if (soft_rst) begin
         wr_bank <= soft_wr(wr_bank);
         rr_bank <= soft_rr(rr_bank);
         tx_pend <= 1'b0;
      end else if (dat_wr) begin
         wr_bank[W_TXD]  <= wdata;
         rr_bank[R_STAT] <= rr_bank[R_STAT] | TXE_BIT;
         rr_bank[R_SPEC] <= rr_bank[R_SPEC] | SENT_BIT;
         tx_pend         <= 1'b1;
      end else if (ctl_wr) begin
         if (ptr == '0) begin
            wr_bank[W_PTR] <= wdata;
         end else if (!cmd_hit) begin
            wr_bank[ptr] <= wdata;
            if ((ptr == PTR_W'(W_RXC)) && ((wdata & HUNT_BIT) != '0)) begin
               rr_bank[R_STAT] <= rr_bank[R_STAT] | HUNT_BIT;
            end
         end
      end
   end

endmodule

// File: rtl/sercom_regbank.sv
module sercom_regbank
   import sercom_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int REG_W    = sercom_pkg::REG_W,
   parameter int REG_N    = sercom_pkg::REG_N,
   parameter bit READ_REG = 1'b0,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int PTR_W   = $clog2(REG_N),
   localparam int BANK_W  = REG_N * REG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CH_W-1:0]          bus_ch,
   input  logic                     bus_is_data,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   output logic [NUM_CH*BANK_W-1:0] cfg_regs,
   output logic [NUM_CH-1:0]        tx_int
);

   if (NUM_CH != 2) begin : g_bad_ch
      $error("sercom_regbank: reset command field addresses exactly two channels");
   end
   if (REG_W != sercom_pkg::REG_W || REG_N != sercom_pkg::REG_N) begin : g_bad_geom
      $error("sercom_regbank: register geometry must match sercom_pkg");
   end

   bank_t            wr_b  [NUM_CH];
   bank_t            rr_b  [NUM_CH];
   logic [PTR_W-1:0] ptr_a [NUM_CH];
   logic [1:0]       cmd_a [NUM_CH];
   logic [1:0]       cmd_any;
   logic             hard_rst;

   logic [NUM_CH*BANK_W-1:0] rr_flat;
   logic [NUM_CH*PTR_W-1:0]  ptr_flat;

   always_comb begin
      cmd_any = 2'b00;
      for (int c = 0; c < NUM_CH; c++) begin
         cmd_any = cmd_any | cmd_a[c];
      end
   end
   assign hard_rst = &cmd_any;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sercom_chan #(.REG_W(REG_W), .REG_N(REG_N)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .acc_en   (bus_ch == CH_W'(c)),
         .is_data  (bus_is_data),
         .wr_en    (bus_wr),
         .rd_en    (bus_rd),
         .wdata    (bus_wdata),
         .soft_rst (cmd_any[c] && !hard_rst),
         .hard_rst (hard_rst),
         .wr_bank  (wr_b[c]),
         .rr_bank  (rr_b[c]),
         .ptr      (ptr_a[c]),
         .tx_pend  (tx_int[c]),
         .cmd_req  (cmd_a[c])
      );
      assign cfg_regs[c*BANK_W +: BANK_W] = wr_b[c];
      assign rr_flat[c*BANK_W +: BANK_W]  = rr_b[c];
      assign ptr_flat[c*PTR_W +: PTR_W]   = ptr_a[c];
   end

   logic [REG_W-1:0] rd_mux;
   logic [PTR_W-1:0] rd_idx;

   assign rd_idx = bus_is_data ? PTR_W'(R_RXD_IDX) : ptr_a[bus_ch];
   assign rd_mux = rr_b[bus_ch][rd_idx];

   localparam int R_RXD_IDX = 8;

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bus_rdata <= '0;
         end else if (bus_rd) begin
            bus_rdata <= rd_mux;
         end
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

endmodule

module sercom_regbank_chk #(
   parameter int NUM_CH = 2,
   parameter int REG_W  = 8,
   parameter int REG_N  = 16,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int PTR_W = $clog2(REG_N),
   localparam int BANK_W = REG_N * REG_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [CH_W-1:0]          bus_ch,
   input logic                     bus_is_data,
   input logic                     bus_wr,
   input logic [REG_W-1:0]         bus_wdata,
   input logic [NUM_CH*BANK_W-1:0] cfg_regs,
   input logic [NUM_CH*BANK_W-1:0] rr_flat,
   input logic [NUM_CH*PTR_W-1:0]  ptr_flat,
   input logic [NUM_CH-1:0]        tx_int
);

   logic             ctl_w;
   logic [PTR_W-1:0] ptr_sel;

   assign ctl_w   = bus_wr && !bus_is_data;
   assign ptr_sel = ptr_flat[bus_ch*PTR_W +: PTR_W];

   // R7: hard reset forces the clock and encoding registers of both channels
   assert_hard_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && ptr_sel == PTR_W'(9) && bus_wdata[7:6] == 2'b11)
      |=> (cfg_regs[11*REG_W +: REG_W] == 8'h08 && cfg_regs[BANK_W + 11*REG_W +: REG_W] == 8'h08
           && cfg_regs[10*REG_W +: REG_W] == 8'h00 && tx_int == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      logic [PTR_W-1:0] p;
      logic [REG_W-1:0] rr0, rr1, rr3;
      assign p   = ptr_flat[c*PTR_W +: PTR_W];
      assign rr0 = rr_flat[c*BANK_W + 0*REG_W +: REG_W];
      assign rr1 = rr_flat[c*BANK_W + 1*REG_W +: REG_W];
      assign rr3 = rr_flat[c*BANK_W + 3*REG_W +: REG_W];

      // R2: pointer loads from the select byte
      assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_w && bus_ch == CH_W'(c) && p == '0)
         |=> (p == {($past(bus_wdata[5:3]) == 3'b001), $past(bus_wdata[2:0])}));

      // R3: pointer returns to zero after a register access
      assert_ptr_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_w && bus_ch == CH_W'(c) && p != '0) |=> (p == '0));

      // R8: hunt entry raises the sync/hunt status bit
      assert_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_w && bus_ch == CH_W'(c) && p == PTR_W'(3) && bus_wdata[4]) |=> rr0[4]);

      // R9: data write marks transmitter empty, all sent, interrupt pending
      assert_tx_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_is_data && bus_ch == CH_W'(c)) |=> (tx_int[c] && rr0[2] && rr1[0]));

      // R6: soft reset of this channel clears pending state
      assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_w && ptr_sel == PTR_W'(9) && bus_wdata[6 + c] && bus_wdata[7:6] != 2'b11)
         |=> (!tx_int[c] && rr3 == '0 && rr0[2] && rr0[6] && p == '0));
   end

endmodule

bind sercom_regbank sercom_regbank_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W), .REG_N(REG_N)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ch      (bus_ch),
   .bus_is_data (bus_is_data),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .cfg_regs    (cfg_regs),
   .rr_flat     (rr_flat),
   .ptr_flat    (ptr_flat),
   .tx_int      (tx_int)
);

// File: tb/tb_sercom_regbank.sv
module tb_sercom_regbank;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [0:0]   bus_ch = '0;
   logic         bus_is_data = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [7:0]   bus_wdata = '0;
   logic [7:0]   bus_rdata;
   logic [255:0] cfg_regs;
   logic [1:0]   tx_int;

   int errors = 0;
   int checks = 0;

   logic [7:0] m_wr [2][16];
   logic [7:0] m_rr [2][16];
   logic       m_tx [2];
   int         m_ptr [2];

   always #4 clk = ~clk;

   sercom_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_ch(bus_ch), .bus_is_data(bus_is_data),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cfg_regs(cfg_regs), .tx_int(tx_int)
   );

   task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, got, exp);
      end
   endtask

   // ---------------- reference model from the requirements ----------------
   task automatic m_soft(input int c);
      m_wr[c][0]  = 8'h00;
      m_wr[c][1]  = m_wr[c][1] & 8'h24;
      m_wr[c][3]  = m_wr[c][3] & 8'hFE;
      m_wr[c][4]  = (m_wr[c][4] & 8'hF3) | 8'h04;
      m_wr[c][5]  = m_wr[c][5] & 8'h61;
      m_wr[c][9]  = m_wr[c][9] & 8'hDF;
      m_wr[c][10] = m_wr[c][10] & 8'h60;
      m_wr[c][14] = (m_wr[c][14] & 8'hC3) | 8'h20;
      m_wr[c][15] = 8'hF8;
      m_rr[c][0]  = (m_rr[c][0] & 8'hB8) | 8'h44;
      m_rr[c][1]  = (m_rr[c][1] & 8'h01) | 8'h06;
      m_rr[c][3]  = 8'h00;
      m_rr[c][10] = m_rr[c][10] & 8'h40;
      m_tx[c]     = 1'b0;
      m_ptr[c]    = 0;
   endtask

   task automatic m_hard_extra(input int c);
      m_wr[c][9]  = (m_wr[c][9] & 8'h03) | 8'hC0;
      m_wr[c][10] = 8'h00;
      m_wr[c][11] = 8'h08;
      m_wr[c][14] = (m_wr[c][14] & 8'hC0) | 8'h30;
   endtask

   task automatic m_ctl(input int c, input logic [7:0] v);
      int p;
      if (m_ptr[c] == 0) begin
         m_wr[c][0] = v;
         m_ptr[c] = int'(v[2:0]) + ((v[5:3] == 3'b001) ? 8 : 0);
      end else begin
         p = m_ptr[c];
         m_ptr[c] = 0;
         if (p == 9 && v[7:6] != 2'b00) begin
            if (v[6]) m_soft(0);
            if (v[7]) m_soft(1);
            if (v[7:6] == 2'b11) begin
               m_hard_extra(0);
               m_hard_extra(1);
            end
         end else begin
            m_wr[c][p] = v;
            if (p == 3 && v[4]) m_rr[c][0] = m_rr[c][0] | 8'h10;
         end
      end
   endtask

   // ---------------- bus tasks ----------------
   task automatic ctl_wr(input int c, input logic [7:0] v);
      @(negedge clk);
      bus_ch = 1'(c); bus_is_data = 1'b0; bus_wr = 1'b1; bus_wdata = v;
      m_ctl(c, v);
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic dat_wr(input int c, input logic [7:0] v);
      @(negedge clk);
      bus_ch = 1'(c); bus_is_data = 1'b1; bus_wr = 1'b1; bus_wdata = v;
      m_wr[c][8] = v;
      m_rr[c][0] = m_rr[c][0] | 8'h04;
      m_rr[c][1] = m_rr[c][1] | 8'h01;
      m_tx[c] = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_is_data = 1'b0;
   endtask

   task automatic bus_read(input int c, input logic dport, output logic [7:0] got);
      @(negedge clk);
      bus_ch = 1'(c); bus_is_data = dport; bus_rd = 1'b1;
      #1 got = bus_rdata;
      if (!dport) m_ptr[c] = 0;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_is_data = 1'b0;
   endtask

   function automatic logic [7:0] sel_byte(input int n);
      return (n >= 8) ? (8'h08 | 8'(n - 8)) : 8'(n);
   endfunction

   task automatic set_ptr(input int c, input int n);
      ctl_wr(c, sel_byte(n));
   endtask

   task automatic wr_reg(input int c, input int n, input logic [7:0] v);
      set_ptr(c, n);
      ctl_wr(c, v);
   endtask

   task automatic check_ch(input int c, input string wtag, input string rtag);
      logic [7:0] got;
      int rr_list [5] = '{0, 1, 3, 8, 10};
      @(negedge clk);
      for (int n = 0; n < 16; n++)
         chk(wtag, $sformatf("ch%0d WR%0d", c, n), cfg_regs[(c*16+n)*8 +: 8], m_wr[c][n]);
      chk(rtag, $sformatf("ch%0d tx_int", c), {7'd0, tx_int[c]}, {7'd0, m_tx[c]});
      for (int k = 0; k < 5; k++) begin
         if (rr_list[k] == 8) begin
            bus_read(c, 1'b1, got);
         end else begin
            if (rr_list[k] != 0) set_ptr(c, rr_list[k]);
            bus_read(c, 1'b0, got);
         end
         chk(rtag, $sformatf("ch%0d RR%0d", c, rr_list[k]), got, m_rr[c][rr_list[k]]);
      end
   endtask

   task automatic fill(input int c, input logic [7:0] pat);
      logic [7:0] v;
      for (int n = 1; n < 16; n++) begin
         v = pat ^ 8'(n * 8'h11);
         if (n == 9) v = v & 8'h3F;
         wr_reg(c, n, v);
      end
      dat_wr(c, pat ^ 8'h3C);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] got;
      logic [7:0] pats [4] = '{8'hFF, 8'h00, 8'h5A, 8'hA5};
      logic [7:0] keep9;
      int writer, other;
      for (int c = 0; c < 2; c++) begin
         m_tx[c] = 1'b0; m_ptr[c] = 0;
         for (int n = 0; n < 16; n++) begin m_wr[c][n] = 8'h00; m_rr[c][n] = 8'h00; end
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: power-on state
      check_ch(0, "R1", "R1");
      check_ch(1, "R1", "R1");

      // R2: point-high decode and plain decode
      ctl_wr(0, 8'h0B);
      ctl_wr(0, 8'h77);
      ctl_wr(0, 8'h13);
      ctl_wr(0, 8'h3E);
      check_ch(0, "R2", "R2");

      // R3: data read leaves the pointer; control read uses it
      dat_wr(1, 8'h81);
      set_ptr(1, 1);
      bus_read(1, 1'b1, got);
      chk("R3", "data-port read RR8", got, 8'h00);
      bus_read(1, 1'b0, got);
      chk("R3", "control read after data read RR1", got, m_rr[1][1]);

      // R8: hunt entry on channel 1 without data-path side effects
      wr_reg(1, 3, 8'h10);
      check_ch(1, "R8", "R8");

      // sweep patterns and every reset command
      foreach (pats[i]) begin
         for (int cmd = 1; cmd <= 3; cmd++) begin
            fill(0, pats[i]);
            fill(1, pats[i] ^ 8'hC3);
            check_ch(0, "R3", "R9");
            check_ch(1, "R3", "R9");
            writer = (cmd == 1) ? 1 : 0;
            other  = (cmd == 1) ? 0 : 1;
            keep9  = m_wr[writer][9];
            wr_reg(writer, 9, {2'(cmd), 6'h15});
            if (cmd != 3) begin
               @(negedge clk);
               chk("R4", "writer WR9 unchanged by command", cfg_regs[(writer*16+9)*8 +: 8], keep9);
               check_ch(other, "R5", "R6");
               check_ch(writer, "R10", "R10");
            end else begin
               check_ch(0, "R7", "R7");
               check_ch(1, "R7", "R7");
            end
         end
      end

      // R4: command 00 is stored as data
      wr_reg(1, 9, 8'h2D);
      @(negedge clk);
      chk("R4", "WR9 stored with command 00", cfg_regs[(16+9)*8 +: 8], 8'h2D);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule